// File: doc/BRIEF.md
# Channel enable and group controller

This block holds the global enable vector that the event router uses to decide which channels carry pulses. Software can rewrite the whole vector, or turn individual channels on or off through set and clear registers where only the bits written as 1 have an effect. Channels can also be enabled or disabled in bulk through a fixed number of channel groups. Each group has a membership mask and two tasks: one turns on all of its members, the other turns them off.

A group task fires in one of two ways. Software can write to the task's register, or the task can subscribe to a channel so that a pulse on that channel fires it without software. Because of this, the channel fabric can switch its own channels, for example a group that shuts itself off after the first event. When requests to turn a channel on and off arrive in the same cycle, the request to turn it on always wins. A group's mask cannot be written while either of that group's subscriptions is active. All accesses go through a flat register port with a combinational read. Security filtering happens upstream of this block.

Top module: `chgc_ctrl`

## Requirements
- R1: After reset, the enable vector, every group mask and every subscribe register read as zero, and `chan_en` is zero.
- R2: A write to offset 0x500 replaces the enable vector with the low channel bits of the write data, and it takes effect at that clock edge. A read of 0x500 returns the vector.
- R3: A write to offset 0x504 turns on each channel whose data bit is 1 and leaves the other channels as they are, so writing zero changes nothing. A read of 0x504 returns the enable vector.
- R4: A write to offset 0x508 turns off each channel whose data bit is 1 and leaves the other channels as they are, so writing zero changes nothing. A read of 0x508 returns the enable vector.
- R5: Writing 1 in bit 0 of offset 0x000+8n fires the enable task of group n, which turns on every member of that group. Writing 1 in bit 0 of offset 0x004+8n fires the disable task, which turns off every member. Writing 0 to either has no effect. Both task registers read as zero.
- R6: The membership mask of group n is at offset 0x800+4n and can be read and written. Bit i set to 1 means channel i is a member.
- R7: The subscribe register of the enable task of group n is at 0x080+8n, and the one for the disable task is at 0x084+8n. Bits [3:0] hold a channel index and bit 31 is the enable. Both read back as written, with the other bits at zero. While bit 31 is set, a pulse on the indexed channel fires the task, and `chan_en` shows the result from the cycle after the pulse. While bit 31 is clear, pulses have no effect.
- R8: A write to the mask of group n is ignored while either subscribe register of group n has its enable set.
- R9: When enable and disable tasks reach the same channel in one cycle, the channel ends up on. This holds whether the two tasks belong to the same group or to different groups.
- R10: In a cycle where a direct set or clear write coincides with group tasks, clears and disables are applied first and sets and enables second. A set therefore overrides a group disable, and a group enable overrides a clear.
- R11: A group whose disable task subscribes to a channel in its own membership shuts off its members after one pulse on that channel. During the pulse cycle the channels are still on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| chan_pulse | input | 16 | One pulse bit per channel from the fabric |
| chan_en | output | 16 | Channel enable vector to the router |

## Verification
The bench builds the block with its default parameters: sixteen channels and six groups. With these values the 4-bit index field covers every channel, and the task, subscribe and mask address ranges reach their last group at offsets 0x028, 0x0AC and 0x814. The bench places enable and disable triggers on one shared channel, both within a single group and across two groups. It also pairs direct set and clear writes with subscribed group tasks in the same cycle, which exercises the order in which the updates are applied.

// File: rtl/chgc_pkg.sv
package chgc_pkg;

  typedef logic [11:0] reg_addr_t;

  localparam reg_addr_t OFS_TASK_LO = 12'h000;
  localparam reg_addr_t OFS_SUB_LO  = 12'h080;
  localparam reg_addr_t OFS_SUB_HI  = 12'h100;
  localparam reg_addr_t OFS_VEC     = 12'h500;
  localparam reg_addr_t OFS_SET     = 12'h504;
  localparam reg_addr_t OFS_CLR     = 12'h508;
  localparam reg_addr_t OFS_MASK_LO = 12'h800;

  typedef enum logic [3:0] {
    K_NONE,
    K_TASK_ON,
    K_TASK_OFF,
    K_SUB_ON,
    K_SUB_OFF,
    K_VEC,
    K_SET,
    K_CLR,
    K_MASK
  } reg_kind_t;

  // clear-side first, then set-side: set-side wins
  function automatic logic [31:0] vec_update(input logic [31:0] base,
                                             input logic [31:0] clr_bits,
                                             input logic [31:0] set_bits);
    return (base & ~clr_bits) | set_bits;
  endfunction

  // subscribe register image: index in low bits, enable in bit 31
  function automatic logic [31:0] sub_image(input logic on, input logic [7:0] idx);
    logic [31:0] r;
    r = 32'(idx);
    r[31] = on;
    return r;
  endfunction

endpackage

// File: rtl/chgc_regdec.sv
module chgc_regdec
  import chgc_pkg::*;
#(
  parameter int NGRP = 6,
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic             reg_wr,
  input  reg_addr_t        reg_addr,
  output reg_kind_t        kind,
  output logic [GW-1:0]    grp,
  output logic [NGRP-1:0]  wr_task_on,
  output logic [NGRP-1:0]  wr_task_off,
  output logic [NGRP-1:0]  wr_sub_on,
  output logic [NGRP-1:0]  wr_sub_off,
  output logic [NGRP-1:0]  wr_mask,
  output logic             wr_vec,
  output logic             wr_set,
  output logic             wr_clr
);

  localparam logic [3:0] NGRP4 = 4'(NGRP);
  localparam reg_addr_t  OFS_MASK_HI = OFS_MASK_LO + 12'(4 * NGRP);

  logic [3:0] slot;
  assign slot = reg_addr[6:3];

  always_comb begin
    kind = K_NONE;
    grp  = '0;
    if (reg_addr[1:0] == 2'b00) begin
      if (reg_addr < OFS_SUB_LO) begin
        if (slot < NGRP4) begin
          kind = reg_addr[2] ? K_TASK_OFF : K_TASK_ON;
          grp  = GW'(slot);
        end
      end else if (reg_addr < OFS_SUB_HI) begin
        if (slot < NGRP4) begin
          kind = reg_addr[2] ? K_SUB_OFF : K_SUB_ON;
          grp  = GW'(slot);
        end
      end else if (reg_addr == OFS_VEC) begin
        kind = K_VEC;
      end else if (reg_addr == OFS_SET) begin
        kind = K_SET;
      end else if (reg_addr == OFS_CLR) begin
        kind = K_CLR;
      end else if (reg_addr >= OFS_MASK_LO && reg_addr < OFS_MASK_HI) begin
        kind = K_MASK;
        grp  = GW'((reg_addr - OFS_MASK_LO) >> 2);
      end
    end
  end

  always_comb begin
    wr_task_on  = '0;
    wr_task_off = '0;
    wr_sub_on   = '0;
    wr_sub_off  = '0;
    wr_mask     = '0;
    wr_vec      = 1'b0;
    wr_set      = 1'b0;
    wr_clr      = 1'b0;
    if (reg_wr) begin
      case (kind)
        K_TASK_ON:  wr_task_on[grp]  = 1'b1;
        K_TASK_OFF: wr_task_off[grp] = 1'b1;
        K_SUB_ON:   wr_sub_on[grp]   = 1'b1;
        K_SUB_OFF:  wr_sub_off[grp]  = 1'b1;
        K_MASK:     wr_mask[grp]     = 1'b1;
        K_VEC:      wr_vec           = 1'b1;
        K_SET:      wr_set           = 1'b1;
        K_CLR:      wr_clr           = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/chgc_group.sv
module chgc_group
  import chgc_pkg::*;
#(
  parameter int NCH = 16,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_task_on,
  input  logic            wr_task_off,
  input  logic            wr_sub_on,
  input  logic            wr_sub_off,
  input  logic            wr_mask,
  input  logic [31:0]     wdata,
  input  logic [NCH-1:0]  chan_pulse,
  output logic [NCH-1:0]  mask_q,
  output logic [31:0]     sub_on_rd,
  output logic [31:0]     sub_off_rd,
  output logic            fire_on,
  output logic            fire_off,
  output logic            locked
);

  logic            son_en_q, soff_en_q;
  logic [IDXW-1:0] son_idx_q, soff_idx_q;
  logic            son_hit, soff_hit;
  logic            unused_grp_wdata;

  assign unused_grp_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      son_en_q   <= 1'b0;
      son_idx_q  <= '0;
      soff_en_q  <= 1'b0;
      soff_idx_q <= '0;
    end else begin
      if (wr_sub_on) begin
        son_en_q  <= wdata[31];
        son_idx_q <= wdata[IDXW-1:0];
      end
      if (wr_sub_off) begin
        soff_en_q  <= wdata[31];
        soff_idx_q <= wdata[IDXW-1:0];
      end
    end
  end

  assign locked = son_en_q | soff_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask && !locked) begin
      mask_q <= wdata[NCH-1:0];
    end
  end

  assign son_hit  = son_en_q  && chan_pulse[son_idx_q];
  assign soff_hit = soff_en_q && chan_pulse[soff_idx_q];

  assign fire_on  = (wr_task_on  && wdata[0]) || son_hit;
  assign fire_off = (wr_task_off && wdata[0]) || soff_hit;

  assign sub_on_rd  = sub_image(son_en_q,  8'(son_idx_q));
  assign sub_off_rd = sub_image(soff_en_q, 8'(soff_idx_q));

  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(mask_q)); // R8

endmodule

// File: rtl/chgc_chen_core.sv
module chgc_chen_core
  import chgc_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int NGRP = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_vec,
  input  logic                      wr_set,
  input  logic                      wr_clr,
  input  logic [NCH-1:0]            wdata,
  input  logic [NGRP-1:0]           fire_on,
  input  logic [NGRP-1:0]           fire_off,
  input  logic [NGRP-1:0][NCH-1:0]  grp_mask,
  output logic [NCH-1:0]            en_q,
  output logic [NCH-1:0]            on_mask,
  output logic [NCH-1:0]            off_mask
);

  logic [NCH-1:0] base, clr_all, set_all, en_nxt;

  always_comb begin
    on_mask  = '0;
    off_mask = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (fire_on[g])  on_mask  = on_mask  | grp_mask[g];
      if (fire_off[g]) off_mask = off_mask | grp_mask[g];
    end
  end

  assign base    = wr_vec ? wdata : en_q;
  assign clr_all = (wr_clr ? wdata : '0) | off_mask;
  assign set_all = (wr_set ? wdata : '0) | on_mask;
  assign en_nxt  = NCH'(vec_update(32'(base), 32'(clr_all), 32'(set_all)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;
  end

  AST_ENABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (on_mask != '0) |=> ((en_q & $past(on_mask)) == $past(on_mask))); // R9

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_vec && !wr_set && on_mask == '0) |=> ((en_q & $past(off_mask)) == '0)); // R5

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && off_mask == '0) |=>
      ((en_q & ($past(en_q) | $past(wdata))) == ($past(en_q) | $past(wdata)))); // R3

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && on_mask == '0) |=>
      (((en_q & $past(wdata)) == '0) && ((en_q & ~$past(en_q)) == '0))); // R4

endmodule

// File: rtl/chgc_ctrl.sv
module chgc_ctrl
  import chgc_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int NGRP = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [11:0]     reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NCH-1:0]  chan_pulse,
  output logic [NCH-1:0]  chan_en
);

  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;

  reg_kind_t                 kind;
  logic [GW-1:0]             grp;
  logic [NGRP-1:0]           wr_task_on, wr_task_off, wr_sub_on, wr_sub_off, wr_mask;
  logic                      wr_vec, wr_set, wr_clr;
  logic [NGRP-1:0][NCH-1:0]  grp_mask;
  logic [NGRP-1:0][31:0]     sub_on_rd, sub_off_rd;
  logic [NGRP-1:0]           fire_on, fire_off, locked;
  logic [NCH-1:0]            en_q, on_mask, off_mask;
  logic                      unused_top_sig;

  assign unused_top_sig = ^{reg_wdata, locked, on_mask, off_mask};

  chgc_regdec #(.NGRP(NGRP)) u_dec (
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .kind        (kind),
    .grp         (grp),
    .wr_task_on  (wr_task_on),
    .wr_task_off (wr_task_off),
    .wr_sub_on   (wr_sub_on),
    .wr_sub_off  (wr_sub_off),
    .wr_mask     (wr_mask),
    .wr_vec      (wr_vec),
    .wr_set      (wr_set),
    .wr_clr      (wr_clr)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    chgc_group #(.NCH(NCH)) u_grp (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_task_on  (wr_task_on[g]),
      .wr_task_off (wr_task_off[g]),
      .wr_sub_on   (wr_sub_on[g]),
      .wr_sub_off  (wr_sub_off[g]),
      .wr_mask     (wr_mask[g]),
      .wdata       (reg_wdata),
      .chan_pulse  (chan_pulse),
      .mask_q      (grp_mask[g]),
      .sub_on_rd   (sub_on_rd[g]),
      .sub_off_rd  (sub_off_rd[g]),
      .fire_on     (fire_on[g]),
      .fire_off    (fire_off[g]),
      .locked      (locked[g])
    );
  end

  chgc_chen_core #(.NCH(NCH), .NGRP(NGRP)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vec   (wr_vec),
    .wr_set   (wr_set),
    .wr_clr   (wr_clr),
    .wdata    (reg_wdata[NCH-1:0]),
    .fire_on  (fire_on),
    .fire_off (fire_off),
    .grp_mask (grp_mask),
    .en_q     (en_q),
    .on_mask  (on_mask),
    .off_mask (off_mask)
  );

  assign chan_en = en_q;

  always_comb begin
    reg_rdata = '0;
    case (kind)
      K_SUB_ON:             reg_rdata = sub_on_rd[grp];
      K_SUB_OFF:            reg_rdata = sub_off_rd[grp];
      K_VEC, K_SET, K_CLR:  reg_rdata = 32'(en_q);
      K_MASK:               reg_rdata = 32'(grp_mask[grp]);
      default:              reg_rdata = '0;
    endcase
  end

  AST_SUB_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_on != '0) |=> (chan_en != '0 || $past(on_mask) == '0)); // R7

endmodule

// File: tb/chgc_ctrl_tb.sv
module chgc_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] chan_pulse = '0;
  logic [15:0] chan_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chgc_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .chan_pulse (chan_pulse),
    .chan_en    (chan_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic [15:0] p);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; chan_pulse = p;
    @(negedge clk);
    reg_wr = 1'b0; chan_pulse = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, a, d, 16'h0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 chan_en", 32'(chan_en), 32'h0);
    rd(12'h500, d); chk("R1 vector", d, 32'h0);
    rd(12'h814, d); chk("R1 mask", d, 32'h0);
    rd(12'h084, d); chk("R1 subscribe", d, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    wr(12'h500, 32'h0000_A5C3);
    chk("R2 vector write", 32'(chan_en), 32'hA5C3);
    rd(12'h500, d); chk("R2 vector read", d, 32'hA5C3);
    rd(12'h504, d); chk("R3 set read", d, 32'hA5C3);
    rd(12'h508, d); chk("R4 clr read", d, 32'hA5C3);
    wr(12'h504, 32'h0F00);
    chk("R3 set ones", 32'(chan_en), 32'hAFC3);
    wr(12'h504, 32'h0);
    chk("R3 set zero", 32'(chan_en), 32'hAFC3);
    wr(12'h508, 32'h00C3);
    chk("R4 clr ones", 32'(chan_en), 32'hAF00);
    wr(12'h508, 32'h0);
    chk("R4 clr zero", 32'(chan_en), 32'hAF00);
  endtask

  task automatic t_group_tasks();
    logic [31:0] d;
    wr(12'h808, 32'h0F0F);
    rd(12'h808, d); chk("R6 mask g2", d, 32'h0F0F);
    wr(12'h814, 32'hF000);
    rd(12'h814, d); chk("R6 mask g5", d, 32'hF000);
    wr(12'h010, 32'h1);
    chk("R5 g2 enable", 32'(chan_en), 32'hAF0F);
    wr(12'h014, 32'h0);
    chk("R5 write zero", 32'(chan_en), 32'hAF0F);
    wr(12'h014, 32'h1);
    chk("R5 g2 disable", 32'(chan_en), 32'hA000);
    rd(12'h010, d); chk("R5 task read", d, 32'h0);
  endtask

  task automatic t_subscribe_priority();
    logic [31:0] d;
    wr(12'h800, 32'h00FF);
    wr(12'h804, 32'h0FF0);
    wr(12'h500, 32'h0);
    wr(12'h080, 32'h0000_0003);
    step(1'b0, 12'h0, 32'h0, 16'h0008);
    chk("R7 disabled subscription", 32'(chan_en), 32'h0);
    wr(12'h080, 32'h8000_0003);
    rd(12'h080, d); chk("R7 readback", d, 32'h8000_0003);
    step(1'b0, 12'h0, 32'h0, 16'h0008);
    chk("R7 pulse enables g0", 32'(chan_en), 32'h00FF);
    wr(12'h084, 32'h8000_0003);
    wr(12'h500, 32'hFFFF);
    step(1'b0, 12'h0, 32'h0, 16'h0008);
    chk("R9 same group", 32'(chan_en), 32'hFFFF);
    wr(12'h08C, 32'h8000_0003);
    step(1'b0, 12'h0, 32'h0, 16'h0008);
    chk("R9 different groups", 32'(chan_en), 32'hF0FF);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(12'h800, 32'h1234);
    rd(12'h800, d); chk("R8 locked g0", d, 32'h00FF);
    wr(12'h804, 32'hAAAA);
    rd(12'h804, d); chk("R8 locked by disable sub", d, 32'h0FF0);
    wr(12'h080, 32'h0);
    wr(12'h084, 32'h0);
    wr(12'h08C, 32'h0);
    wr(12'h800, 32'h1234);
    rd(12'h800, d); chk("R8 unlocked", d, 32'h1234);
  endtask

  task automatic t_order();
    wr(12'h500, 32'h0F0F);
    wr(12'h094, 32'h8000_0005);
    step(1'b1, 12'h504, 32'h0100, 16'h0020);
    chk("R10 set over disable", 32'(chan_en), 32'h0100);
    wr(12'h090, 32'h8000_0006);
    step(1'b1, 12'h508, 32'h0F0F, 16'h0040);
    chk("R10 enable over clear", 32'(chan_en), 32'h0F0F);
    wr(12'h090, 32'h0);
    wr(12'h094, 32'h0);
  endtask

  task automatic t_self_off();
    wr(12'h500, 32'h0);
    wr(12'h0AC, 32'h8000_000C);
    wr(12'h028, 32'h1);
    chk("R5 g5 enable", 32'(chan_en), 32'hF000);
    @(negedge clk);
    chan_pulse = 16'h1000;
    #1 chk("R11 during pulse", 32'(chan_en), 32'hF000);
    @(negedge clk);
    chan_pulse = '0;
    #1 chk("R11 after pulse", 32'(chan_en), 32'h0);
    step(1'b0, 12'h0, 32'h0, 16'h1000);
    chk("R11 second pulse", 32'(chan_en), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_direct();
    t_group_tasks();
    t_subscribe_priority();
    t_lock();
    t_order();
    t_self_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule